// File: doc/BRIEF.md
# Byte-Wide Management Interface Host Transaction Engine

This block runs one full request/response exchange with a remote management controller. The controller is reached through three byte-wide registers on a simple synchronous bus: data, control/status and flags. Software first fills a local request buffer through a write port. It then pulses `start` with the request length. The engine pushes the request out one byte at a time and gathers the answer into a local response buffer, which the host reads back by address.

Each step of the exchange is a small handshake. The engine writes a control code, writes a data byte if the step carries one, and then writes the flags register with the busy bit set. After that it polls the flags register until the remote side clears busy. It then reads the status code and checks it against the code the step expects. Any unexpected status, a nonzero error byte or a stalled step makes the engine start the exchange again from the beginning. Once the retry budget is spent it reports a failure.

When no exchange is running, the engine keeps polling the flags register. It raises an attention output whenever the remote side reports a pending event or message.

Top module: `smic_host_engine`

## Requirements
- R1: Register addresses are data at 0, control/status at 1 and flags at 2. The engine never reads and writes in the same cycle. It never writes while the remote busy flag (flags bit 0) is set. Every step ends with a flags write that has bit 0 set.
- R2: A `start` pulse is accepted only while idle and with a length from 2 to REQ_DEPTH (80). Otherwise `reject` pulses in the next cycle and the running or idle state is not disturbed.
- R3: The write phase issues 0x40 and expects status 0xC0. It then sends byte 0 with 0x41, each middle byte with 0x42 and the last byte with 0x43. A byte is sent only when the TX-ready flag (bit 6) is set. The statuses expected after these codes are 0xC1 and 0xC2.
- R4: After the last request byte the status must read 0xC3 and the data register must read 0x00.
- R5: The read phase waits for RX-ready (flags bit 7) and then issues 0x44. It expects 0xC4 and reads byte 0. Each further byte is read under status 0xC5 and followed by 0x45. Under status 0xC6 the final byte is read and 0x46 is issued. A following status of 0xC0 with data 0x00 completes the exchange with a `done` pulse, and `rsp_len` then equals the number of bytes received.
- R6: A wrong status code or a nonzero error byte restarts the exchange at 0x40 and resends the whole request.
- R7: If no step succeeds within TMO_CYCLES cycles, the exchange restarts, as it does for R6.
- R8: The fourth consecutive failure ends the exchange with a `fail` pulse and returns the engine to idle. A new request is then accepted.
- R9: Response bytes beyond RSP_DEPTH are still read from the data register but are discarded. `rsp_trunc` is then set at `done`, and `rsp_len` equals RSP_DEPTH.
- R10: While idle and not busy, `attn` follows whether any of flags bits 4, 3 or 2 is set.
- R11: `busy` is high from acceptance until the cycle in which `done` or `fail` pulses. `done` and `fail` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_we | input | 1 | Request buffer write strobe |
| req_waddr | input | $clog2(REQ_DEPTH) | Request buffer write address |
| req_wdata | input | 8 | Request byte |
| start | input | 1 | Start an exchange |
| start_len | input | $clog2(REQ_DEPTH+1) | Request length in bytes |
| rsp_raddr | input | $clog2(RSP_DEPTH) | Response buffer read address |
| rsp_rdata | output | 8 | Response byte, one cycle after the address |
| bus_addr | output | 2 | Remote register address |
| bus_wr | output | 1 | Remote register write strobe |
| bus_wdata | output | 8 | Remote register write data |
| bus_rd | output | 1 | Remote register read strobe |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange completed (pulse) |
| fail | output | 1 | Retries exhausted (pulse) |
| reject | output | 1 | Start refused (pulse) |
| attn | output | 1 | Remote side has pending work while idle |
| rsp_len | output | $clog2(RSP_DEPTH+1) | Bytes stored by the last completed exchange |
| rsp_trunc | output | 1 | Last completed response overflowed the buffer |

## Verification
The hardest case to reach is the timeout. A correct remote side always releases busy within a few cycles. The bench's remote model can therefore be told to hold busy for longer than the timeout on one chosen step. This forces a restart while the remote side is still working, and the engine must keep polling until busy drops before it issues a new control code. The retry limit is reached in a similar way, by telling the model to return a nonzero error byte a set number of times. Truncation is reached by having the model answer with more bytes than the buffer holds.

// File: rtl/smic_pkg.sv
package smic_pkg;
  localparam logic [1:0] REG_DATA  = 2'd0;
  localparam logic [1:0] REG_CS    = 2'd1;
  localparam logic [1:0] REG_FLAGS = 2'd2;

  localparam int BIT_RX   = 7;
  localparam int BIT_TX   = 6;
  localparam int BIT_BUSY = 0;
  localparam logic [7:0] EVT_MASK = 8'h1C;

  localparam logic [7:0] OP_GET    = 8'h40;
  localparam logic [7:0] OP_WFIRST = 8'h41;
  localparam logic [7:0] OP_WMID   = 8'h42;
  localparam logic [7:0] OP_WLAST  = 8'h43;
  localparam logic [7:0] OP_RFIRST = 8'h44;
  localparam logic [7:0] OP_RMID   = 8'h45;
  localparam logic [7:0] OP_RLAST  = 8'h46;
  localparam logic [7:0] RESP_BIT  = 8'h80;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_CHECK_WAIT, S_WFIRST, S_WMID, S_WLAST,
    S_TURN, S_RFIRST, S_RMID, S_RLAST
  } xact_e;

  typedef enum logic [3:0] {
    P_FLG_RD, P_FLG_CAP, P_STS_RD, P_STS_CAP, P_DAT_RD, P_DAT_CAP,
    P_WR_CTL, P_WR_DAT, P_WR_FLG
  } phase_e;

  typedef enum logic [2:0] {
    A_SEQ, A_POLL, A_STS, A_STEP, A_RDDAT, A_ADV, A_DONE, A_RETRY
  } act_e;
endpackage

// File: rtl/smic_byte_ram.sv
module smic_byte_ram #(
  parameter int DEPTH = 80,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smic_step_timer.sv
module smic_step_timer #(
  parameter int TMO_CYCLES = 1000,
  localparam int TW = $clog2(TMO_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic run,
  output logic expired
);
  localparam logic [TW-1:0] LOAD = TW'(TMO_CYCLES);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload)           cnt <= LOAD;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  assert_tmo_bound_R7: assert property (@(posedge clk) disable iff (rst) cnt <= LOAD);
endmodule

// File: rtl/smic_host_engine.sv
module smic_host_engine
  import smic_pkg::*;
#(
  parameter int REQ_DEPTH  = 80,
  parameter int RSP_DEPTH  = 80,
  parameter int MIN_REQ    = 2,
  parameter int TMO_CYCLES = 1000,
  parameter int MAX_RETRY  = 3,
  localparam int QAW = $clog2(REQ_DEPTH),
  localparam int LW  = $clog2(REQ_DEPTH + 1),
  localparam int RAW = $clog2(RSP_DEPTH),
  localparam int RW  = $clog2(RSP_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_we,
  input  logic [QAW-1:0] req_waddr,
  input  logic [7:0]     req_wdata,
  input  logic           start,
  input  logic [LW-1:0]  start_len,
  input  logic [RAW-1:0] rsp_raddr,
  output logic [7:0]     rsp_rdata,
  output logic [1:0]     bus_addr,
  output logic           bus_wr,
  output logic [7:0]     bus_wdata,
  output logic           bus_rd,
  input  logic [7:0]     bus_rdata,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic           reject,
  output logic           attn,
  output logic [RW-1:0]  rsp_len,
  output logic           rsp_trunc
);
  localparam int CW = $clog2(MAX_RETRY + 2);
  localparam logic [RW-1:0] RSP_FULL = RW'(RSP_DEPTH);
  localparam logic [CW-1:0] RETRY_MAX = CW'(MAX_RETRY);

  xact_e  st, nxt_st, d_nst;
  phase_e ph;
  act_e   act;
  logic [7:0]    flags_q, ctl_q, d_ctl, req_byte;
  logic          has_dat, d_dat, tmo_exp, accept, len_ok, last_byte, rsp_we;
  logic [LW-1:0] wr_pos, len_q;
  logic [RW-1:0] rd_pos;
  logic [CW-1:0] retries;
  logic          trunc;

  smic_byte_ram #(.DEPTH(REQ_DEPTH)) req_ram_i (
    .clk(clk), .we(req_we), .waddr(req_waddr), .wdata(req_wdata),
    .raddr(wr_pos[QAW-1:0]), .rdata(req_byte));

  assign rsp_we = (ph == P_DAT_CAP) && (st == S_RFIRST || st == S_RMID) && (rd_pos < RSP_FULL);
  smic_byte_ram #(.DEPTH(RSP_DEPTH)) rsp_ram_i (
    .clk(clk), .we(rsp_we), .waddr(rd_pos[RAW-1:0]), .wdata(bus_rdata),
    .raddr(rsp_raddr), .rdata(rsp_rdata));

  assign busy      = (st != S_IDLE);
  assign len_ok    = (start_len >= LW'(MIN_REQ)) && (start_len <= LW'(REQ_DEPTH));
  assign accept    = start && !busy && len_ok;
  assign last_byte = (wr_pos == len_q - LW'(1));

  smic_step_timer #(.TMO_CYCLES(TMO_CYCLES)) timer_i (
    .clk(clk), .rst(rst),
    .reload(accept || act == A_STEP || act == A_ADV || act == A_RETRY),
    .run(busy), .expired(tmo_exp));

  // Decision taken at each capture phase.
  always_comb begin
    act = A_SEQ; d_ctl = ctl_q; d_nst = st; d_dat = 1'b0;
    unique case (ph)
      P_FLG_CAP: begin
        if (busy && tmo_exp)                      act = A_RETRY;
        else if (bus_rdata[BIT_BUSY] || !busy)    act = A_POLL;
        else                                      act = A_STS;
      end
      P_STS_CAP: begin
        unique case (st)
          S_CHECK: begin act = A_STEP; d_ctl = OP_GET; d_nst = S_CHECK_WAIT; end
          S_CHECK_WAIT: begin
            if (bus_rdata != (OP_GET | RESP_BIT)) act = A_RETRY;
            else begin act = A_STEP; d_ctl = OP_WFIRST; d_dat = 1'b1; d_nst = S_WFIRST; end
          end
          S_WFIRST, S_WMID: begin
            if (bus_rdata != (((st == S_WFIRST) ? OP_WFIRST : OP_WMID) | RESP_BIT)) act = A_RETRY;
            else if (!flags_q[BIT_TX]) act = A_POLL;
            else begin
              act = A_STEP; d_dat = 1'b1;
              d_ctl = last_byte ? OP_WLAST : OP_WMID;
              d_nst = last_byte ? S_WLAST : S_WMID;
            end
          end
          S_WLAST: act = (bus_rdata != (OP_WLAST | RESP_BIT)) ? A_RETRY : A_RDDAT;
          S_TURN: begin
            if (flags_q[BIT_RX]) begin act = A_STEP; d_ctl = OP_RFIRST; d_nst = S_RFIRST; end
            else act = A_POLL;
          end
          S_RFIRST: begin
            if (bus_rdata != (OP_RFIRST | RESP_BIT)) act = A_RETRY;
            else if (!flags_q[BIT_RX]) act = A_POLL;
            else begin act = A_RDDAT; d_ctl = OP_RMID; d_nst = S_RMID; end
          end
          S_RMID: begin
            if (bus_rdata == (OP_RLAST | RESP_BIT)) begin act = A_RDDAT; d_ctl = OP_RLAST; d_nst = S_RLAST; end
            else if (bus_rdata != (OP_RMID | RESP_BIT)) act = A_RETRY;
            else if (!flags_q[BIT_RX]) act = A_POLL;
            else begin act = A_RDDAT; d_ctl = OP_RMID; d_nst = S_RMID; end
          end
          S_RLAST: act = (bus_rdata != (OP_GET | RESP_BIT)) ? A_RETRY : A_RDDAT;
          default: act = A_POLL;
        endcase
      end
      P_DAT_CAP: begin
        if (st == S_WLAST || st == S_RLAST) begin
          if (bus_rdata != 8'h00) act = A_RETRY;
          else act = (st == S_WLAST) ? A_ADV : A_DONE;
        end else begin
          act = A_STEP; d_nst = nxt_st;
        end
      end
      default: act = A_SEQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= P_FLG_RD; nxt_st <= S_IDLE;
      flags_q <= '0; ctl_q <= '0; has_dat <= 1'b0;
      wr_pos <= '0; len_q <= '0; rd_pos <= '0; trunc <= 1'b0; retries <= '0;
      done <= 1'b0; fail <= 1'b0; reject <= 1'b0; attn <= 1'b0;
      rsp_len <= '0; rsp_trunc <= 1'b0;
    end else begin
      done <= 1'b0; fail <= 1'b0; reject <= 1'b0;
      if (accept) begin
        st <= S_CHECK; ph <= P_FLG_RD; len_q <= start_len;
        wr_pos <= '0; rd_pos <= '0; trunc <= 1'b0; retries <= '0; attn <= 1'b0;
      end else begin
        if (start) reject <= 1'b0 | 1'b1;
        if (ph == P_FLG_CAP) begin
          flags_q <= bus_rdata;
          if (!busy && !bus_rdata[BIT_BUSY]) attn <= |(bus_rdata & EVT_MASK);
        end
        if (ph == P_WR_DAT) wr_pos <= wr_pos + 1'b1;
        if (ph == P_DAT_CAP && (st == S_RFIRST || st == S_RMID)) begin
          if (rd_pos < RSP_FULL) rd_pos <= rd_pos + 1'b1;
          else                   trunc  <= 1'b1;
        end
        unique case (act)
          A_SEQ: begin
            unique case (ph)
              P_FLG_RD: ph <= P_FLG_CAP;
              P_STS_RD: ph <= P_STS_CAP;
              P_DAT_RD: ph <= P_DAT_CAP;
              P_WR_CTL: ph <= has_dat ? P_WR_DAT : P_WR_FLG;
              P_WR_DAT: ph <= P_WR_FLG;
              default:  ph <= P_FLG_RD;
            endcase
          end
          A_POLL:  ph <= P_FLG_RD;
          A_STS:   ph <= P_STS_RD;
          A_STEP:  begin ctl_q <= d_ctl; has_dat <= d_dat; st <= d_nst; ph <= P_WR_CTL; end
          A_RDDAT: begin ctl_q <= d_ctl; nxt_st <= d_nst; ph <= P_DAT_RD; end
          A_ADV:   begin st <= S_TURN; ph <= P_FLG_RD; end
          A_DONE:  begin
            st <= S_IDLE; ph <= P_FLG_RD; done <= 1'b1;
            rsp_len <= rd_pos; rsp_trunc <= trunc;
          end
          A_RETRY: begin
            ph <= P_FLG_RD;
            if (retries == RETRY_MAX) begin
              st <= S_IDLE; fail <= 1'b1;
            end else begin
              retries <= retries + 1'b1; st <= S_CHECK;
              wr_pos <= '0; rd_pos <= '0; trunc <= 1'b0;
            end
          end
          default: ph <= P_FLG_RD;
        endcase
      end
    end
  end

  // Bus strobes decoded from the phase register.
  always_comb begin
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = REG_DATA; bus_wdata = 8'h00;
    unique case (ph)
      P_FLG_RD: begin bus_rd = 1'b1; bus_addr = REG_FLAGS; end
      P_STS_RD: begin bus_rd = 1'b1; bus_addr = REG_CS; end
      P_DAT_RD: begin bus_rd = 1'b1; bus_addr = REG_DATA; end
      P_WR_CTL: begin bus_wr = 1'b1; bus_addr = REG_CS; bus_wdata = ctl_q; end
      P_WR_DAT: begin bus_wr = 1'b1; bus_addr = REG_DATA; bus_wdata = req_byte; end
      P_WR_FLG: begin bus_wr = 1'b1; bus_addr = REG_FLAGS; bus_wdata = flags_q | 8'h01; end
      default: ;
    endcase
  end

  assert_rw_excl_R1: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr));
  assert_ctl_then_flags_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_CS) |=> (bus_wr && (bus_addr == REG_DATA || bus_addr == REG_FLAGS)));
  assert_reject_busy_R2: assert property (@(posedge clk) disable iff (rst) (start && busy) |=> reject);
  assert_retry_bound_R8: assert property (@(posedge clk) disable iff (rst) retries <= RETRY_MAX);
  assert_rsp_bound_R9: assert property (@(posedge clk) disable iff (rst) rd_pos <= RSP_FULL);
  assert_attn_idle_R10: assert property (@(posedge clk) disable iff (rst) attn |-> !busy);
  assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (done || fail));
  assert_outcome_excl_R11: assert property (@(posedge clk) disable iff (rst) !(done && fail));
endmodule

// File: tb/smic_host_engine_tb_top.sv
module smic_host_engine_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       req_we = 1'b0, start = 1'b0;
  logic [6:0] req_waddr = '0, start_len = '0, rsp_raddr = '0;
  logic [7:0] req_wdata = '0, rsp_rdata, bus_wdata, bus_rdata;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd, busy, done, fail, reject, attn, rsp_trunc;
  logic [6:0] rsp_len;

  smic_host_engine #(.TMO_CYCLES(64)) dut_i (
    .clk(clk), .rst(rst), .req_we(req_we), .req_waddr(req_waddr), .req_wdata(req_wdata),
    .start(start), .start_len(start_len), .rsp_raddr(rsp_raddr), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .fail(fail), .reject(reject),
    .attn(attn), .rsp_len(rsp_len), .rsp_trunc(rsp_trunc));

  int n_chk = 0, n_bad = 0;

  // Remote controller model.
  logic       dv_busy, dv_rx;
  logic [2:0] dv_evt = 3'b000;
  logic [7:0] dv_status, dv_out, dv_ctl, dv_din;
  int dv_cnt, rx_idx;
  int got_n = 0, n_ctl = 0, n_get = 0, viol = 0;
  int resp_n = 2, hang_left = 0, bad_left = 0, wr_err_left = 0, rd_err_left = 0;
  logic [7:0] resp_mem [0:127];
  logic [7:0] got [0:127];
  logic [7:0] ctl_log [0:255];
  logic [7:0] exp_req [0:127];

  always @(posedge clk) begin
    if (rst) begin
      dv_busy <= 1'b0; dv_rx <= 1'b0; dv_status <= 8'hC0; dv_out <= 8'h00;
      dv_ctl <= 8'h00; dv_din <= 8'h00; dv_cnt = 0; bus_rdata <= 8'h00; rx_idx = 0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          2'd2:    bus_rdata <= {dv_rx, 1'b1, 1'b0, dv_evt, 1'b0, dv_busy};
          2'd1:    bus_rdata <= dv_status;
          default: bus_rdata <= dv_out;
        endcase
      end
      if (bus_wr) begin
        if (dv_busy) viol = viol + 1;
        if (bus_addr == 2'd1) begin
          dv_ctl <= bus_wdata;
          if (n_ctl < 256) ctl_log[n_ctl] = bus_wdata;
          n_ctl = n_ctl + 1;
        end else if (bus_addr == 2'd0) dv_din <= bus_wdata;
        else if (bus_addr == 2'd2) begin
          if (!bus_wdata[0]) viol = viol + 1;
          dv_busy <= 1'b1;
          if (hang_left > 0) begin dv_cnt = 100; hang_left = hang_left - 1; end
          else dv_cnt = 3;
        end
      end else if (dv_cnt != 0) begin
        dv_cnt = dv_cnt - 1;
        if (dv_cnt == 0) begin
          dv_busy <= 1'b0;
          case (dv_ctl)
            8'h40: begin dv_status <= 8'hC0; dv_rx <= 1'b0; n_get = n_get + 1; end
            8'h41: begin
              got[0] = dv_din; got_n = 1;
              if (bad_left > 0) begin dv_status <= 8'hC9; bad_left = bad_left - 1; end
              else dv_status <= 8'hC1;
            end
            8'h42: begin dv_status <= 8'hC2; got[got_n] = dv_din; got_n = got_n + 1; end
            8'h43: begin
              dv_status <= 8'hC3; got[got_n] = dv_din; got_n = got_n + 1;
              if (wr_err_left > 0) begin dv_out <= 8'h55; wr_err_left = wr_err_left - 1; end
              else begin dv_out <= 8'h00; dv_rx <= 1'b1; end
            end
            8'h44: begin dv_status <= 8'hC4; dv_out <= resp_mem[0]; rx_idx = 0; end
            8'h45: begin
              rx_idx = rx_idx + 1; dv_out <= resp_mem[rx_idx];
              dv_status <= (rx_idx == resp_n - 1) ? 8'hC6 : 8'hC5;
            end
            8'h46: begin
              dv_status <= 8'hC0; dv_rx <= 1'b0;
              if (rd_err_left > 0) begin dv_out <= 8'h33; rd_err_left = rd_err_left - 1; end
              else dv_out <= 8'h00;
            end
            default: dv_status <= 8'hFF;
          endcase
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_req(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      exp_req[i] = 8'((i * 13 + len + 5) & 255);
      req_we = 1'b1; req_waddr = 7'(i); req_wdata = exp_req[i];
    end
    @(negedge clk); req_we = 1'b0;
  endtask

  task automatic set_resp(input int n);
    resp_n = n;
    for (int i = 0; i < n; i++) resp_mem[i] = 8'((i * 29 + n + 1) & 255);
  endtask

  task automatic do_start(input int len, output bit rej);
    @(negedge clk); start = 1'b1; start_len = 7'(len);
    @(negedge clk); rej = reject; start = 1'b0;
  endtask

  task automatic wait_end(output bit d, output bit f);
    d = 0; f = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done) begin d = 1; break; end
      if (fail) begin f = 1; break; end
    end
  endtask

  task automatic rd_rsp(input int a, output int v);
    @(negedge clk); rsp_raddr = 7'(a);
    @(negedge clk); v = rsp_rdata;
  endtask

  task automatic run_xact(input int len, input int rn, output bit d, output bit f);
    bit rej;
    load_req(len); set_resp(rn);
    got_n = 0; n_ctl = 0; n_get = 0;
    do_start(len, rej);
    wait_end(d, f);
  endtask

  task automatic check_payload(input string tag, input int len, input int rn);
    int v; bit ok = 1;
    for (int i = 0; i < len; i++) if (got[i] !== exp_req[i]) ok = 0;
    chk(ok && got_n == len, {tag, " request bytes"}, got_n, len);
    chk(rsp_len == 7'(rn), {tag, " rsp_len"}, rsp_len, rn);
    ok = 1;
    for (int i = 0; i < rn; i++) begin rd_rsp(i, v); if (v != resp_mem[i]) ok = 0; end
    chk(ok, {tag, " response bytes"}, ok, 1);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fail && !reject && !attn, "R11 reset outputs quiet", busy, 0);
    chk(rsp_len == 0 && !rsp_trunc, "R9 reset rsp_len", rsp_len, 0);
  endtask

  task automatic t_basic;
    bit d, f; bit ok = 1;
    logic [7:0] seq [10] = '{8'h40,8'h41,8'h42,8'h43,8'h44,8'h45,8'h45,8'h45,8'h45,8'h46};
    run_xact(3, 5, d, f);
    chk(d && !f && !busy, "R5 basic done", d, 1);
    chk(n_ctl == 10, "R3 control count", n_ctl, 10);
    for (int i = 0; i < 10; i++) if (ctl_log[i] != seq[i]) ok = 0;
    chk(ok, "R3 R5 control sequence", ok, 1);
    check_payload("R3 R5 basic", 3, 5);
    chk(!rsp_trunc, "R9 no truncation", rsp_trunc, 0);
    chk(viol == 0, "R1 handshake order", viol, 0);
  endtask

  task automatic t_min;
    bit d, f; bit ok;
    run_xact(2, 2, d, f);
    ok = (n_ctl == 6) && ctl_log[1] == 8'h41 && ctl_log[2] == 8'h43 && ctl_log[3] == 8'h44 && ctl_log[5] == 8'h46;
    chk(d && ok, "R3 two-byte request sequence", n_ctl, 6);
    check_payload("R4 R5 minimal", 2, 2);
  endtask

  task automatic t_reject;
    bit rej, d, f;
    do_start(1, rej);
    chk(rej && !busy, "R2 length 1 rejected", rej, 1);
    do_start(81, rej);
    chk(rej && !busy, "R2 length 81 rejected", rej, 1);
    load_req(4); set_resp(3); got_n = 0; n_ctl = 0;
    do_start(4, rej);
    chk(!rej && busy, "R2 valid start accepted", busy, 1);
    do_start(6, rej);
    chk(rej && busy, "R2 start while busy rejected", rej, 1);
    wait_end(d, f);
    chk(d && got_n == 4, "R2 busy start had no effect", got_n, 4);
  endtask

  task automatic t_attn;
    dv_evt = 3'b010;
    repeat (10) @(negedge clk);
    chk(attn == 1'b1, "R10 attention raised", attn, 1);
    dv_evt = 3'b000;
    repeat (10) @(negedge clk);
    chk(attn == 1'b0, "R10 attention cleared", attn, 0);
  endtask

  task automatic t_bad_status;
    bit d, f;
    bad_left = 1;
    run_xact(5, 4, d, f);
    chk(d && n_get == 2, "R6 bad status restarts", n_get, 2);
    check_payload("R6 after restart", 5, 4);
  endtask

  task automatic t_wr_err;
    bit d, f;
    wr_err_left = 2;
    run_xact(4, 3, d, f);
    chk(d && n_get == 3, "R4 R6 write error byte restarts", n_get, 3);
  endtask

  task automatic t_rd_err;
    bit d, f;
    rd_err_left = 1;
    run_xact(3, 3, d, f);
    chk(d && n_get == 2, "R5 R6 read error byte restarts", n_get, 2);
  endtask

  task automatic t_timeout;
    bit d, f;
    hang_left = 1;
    run_xact(3, 2, d, f);
    chk(d && !f && n_get == 2, "R7 timeout restarts", n_get, 2);
    chk(viol == 0, "R1 no write while busy", viol, 0);
  endtask

  task automatic t_fatal;
    bit d, f;
    wr_err_left = 4;
    run_xact(3, 2, d, f);
    chk(f && !d && !busy, "R8 fail after four errors", f, 1);
    chk(n_get == 4, "R8 four attempts", n_get, 4);
    wr_err_left = 0;
    run_xact(2, 3, d, f);
    chk(d, "R8 accepted after fail", d, 1);
  endtask

  task automatic t_trunc;
    bit d, f; int v;
    run_xact(80, 83, d, f);
    chk(d && rsp_len == 7'd80, "R9 truncated length", rsp_len, 80);
    chk(rsp_trunc, "R9 truncation flag", rsp_trunc, 1);
    rd_rsp(79, v);
    chk(v == resp_mem[79], "R9 last kept byte", v, resp_mem[79]);
    chk(got_n == 80, "R3 longest request", got_n, 80);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_min;
    t_reject;
    t_attn;
    t_bad_status;
    t_wr_err;
    t_rd_err;
    t_timeout;
    t_fatal;
    t_trunc;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule